// File: doc/BRIEF.md
# Time-Multiplexed PCM Space Switch

This block joins a set of incoming PCM highways to a set of outgoing PCM highways, where every highway carries a fixed number of time-slot channels per frame and one 8-bit sample moves in parallel per slot. Each outgoing highway has its own connection memory holding one entry per time slot. The entry names the incoming highway whose sample goes to that output in that slot. A shared slot counter reads all connection memories in step with the frame. The entry read for the current slot is decoded into one enable line per crosspoint. Each crosspoint is an AND of highway data and its enable, and the gated samples are ORed onto the output register.

Because the crosspoint settings are reloaded every slot, a single crosspoint array behaves as a separate input-by-output switch for every time slot of the frame. A controlling processor sets up and clears connections through a write port that carries an output index, a slot index, an input number and a valid flag. All incoming highways are assumed to be frame-aligned already. A frame-sync pulse marks slot 0.

Top module: `pcm_space_switch`

## Requirements
- R1: After reset every output highway reads 0 and every connection entry is empty, so outputs stay 0 until entries are written.
- R2: A cycle with `frame_sync` high is slot 0. Otherwise the slot advances by one per cycle and wraps from N_SLOT-1 to 0 without a sync.
- R3: Input highway i occupies `hw_in[i*8 +: 8]` and output j occupies `hw_out[j*8 +: 8]`. In the cycle after a cycle in slot s, output j holds the sample present in that cycle on the input named by entry (j, s).
- R4: The entries of one output for different slots are independent, so an output may take a different input in every slot.
- R5: Several outputs may take the same input in the same slot. Each of them then carries that sample.
- R6: An entry whose valid flag is clear enables no crosspoint, and the output carries 0 for that slot.
- R7: A valid entry whose input number is N_IN or larger enables no crosspoint, and the output carries 0.
- R8: A write takes effect at the clock edge that ends its cycle. A write to the slot being read in that cycle does not affect that cycle's sample and applies from the next frame. A write to the following slot applies in the next cycle.
- R9: At most one crosspoint of a column is enabled in any cycle.
- R10: A write changes only the entry addressed by its output and slot indices.
- R11: A write whose output index is N_OUT or larger changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one time slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| frame_sync | input | 1 | Marks the current cycle as slot 0 |
| hw_in | input | N_IN*8 | Incoming highway samples, highway i at bits i*8 and up |
| hw_out | output | N_OUT*8 | Outgoing highway samples, registered |
| wr_en | input | 1 | Connection write strobe |
| wr_col | input | COL_W | Output highway index of the write |
| wr_slot | input | SLOT_W | Time slot index of the write |
| wr_src | input | SRC_W | Input highway number to connect |
| wr_valid | input | 1 | Valid flag of the written entry |

## Verification
The hardest situation to reach is a write that lands on the slot being read in that same cycle. From the ports, the slot in progress is only visible through the data pattern on the outputs. The bench therefore keeps its own frame-position model, which is resynchronised on every `frame_sync` pulse. It uses that model to aim writes at the current slot and at the following slot, and then checks that the old entry still governs the current sample. Out-of-range input numbers and output indices are reached by using the spare codes of the narrow write fields.

// File: rtl/pcm_sw_pkg.sv
package pcm_sw_pkg;

    localparam int SAMPLE_W = 8;

    typedef logic [SAMPLE_W-1:0] sample_t;

    // index width for a count, never below one bit
    function automatic int idx_w(input int count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction

endpackage

// File: rtl/pcm_slot_ctr.sv
module pcm_slot_ctr #(
    parameter int N_SLOT = 8,
    localparam int SLOT_W = pcm_sw_pkg::idx_w(N_SLOT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_sync,
    output logic [SLOT_W-1:0] cur_slot
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(N_SLOT - 1);

    logic [SLOT_W-1:0] slot_q;
    logic [SLOT_W-1:0] slot_nxt;

    always_comb begin
        cur_slot = frame_sync ? '0 : slot_q;
        slot_nxt = (cur_slot == LAST) ? '0 : cur_slot + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) slot_q <= '0;
        else     slot_q <= slot_nxt;
    end

    AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (rst)
        frame_sync |=> (slot_q == SLOT_W'(1 % N_SLOT))); // R2
    AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!frame_sync && slot_q == LAST) |=> (slot_q == '0)); // R2
endmodule

// File: rtl/pcm_conn_mem.sv
module pcm_conn_mem #(
    parameter int N_IN   = 5,
    parameter int N_SLOT = 8,
    localparam int SRC_W  = pcm_sw_pkg::idx_w(N_IN),
    localparam int SLOT_W = pcm_sw_pkg::idx_w(N_SLOT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [SRC_W-1:0]  wr_src,
    input  logic              wr_valid,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [N_IN-1:0]   xp_en
);
    typedef struct packed {
        logic             vld;
        logic [SRC_W-1:0] src;
    } entry_t;

    entry_t mem_q [N_SLOT];
    entry_t rd_ent;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < N_SLOT; s++) mem_q[s] <= '0;
        end else if (wr_en && (int'(wr_slot) < N_SLOT)) begin
            mem_q[wr_slot] <= '{vld: wr_valid, src: wr_src};
        end
    end

    // read port follows the slot counter; a same-cycle write lands after this read
    assign rd_ent = mem_q[rd_slot];

    // decoder: one enable line per crosspoint, none for empty or out-of-range entries
    for (genvar i = 0; i < N_IN; i++) begin : g_dec
        assign xp_en[i] = rd_ent.vld && (rd_ent.src == SRC_W'(i));
    end

    AST_XP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(xp_en)); // R9
endmodule

// File: rtl/pcm_xpoint_col.sv
module pcm_xpoint_col #(
    parameter int N_IN = 5
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic [N_IN*pcm_sw_pkg::SAMPLE_W-1:0]  hw_in,
    input  logic [N_IN-1:0]                       xp_en,
    output pcm_sw_pkg::sample_t                   col_out
);
    import pcm_sw_pkg::*;

    sample_t gated [N_IN];
    sample_t merged;

    // crosspoints: each one ANDs a highway sample with its enable
    for (genvar i = 0; i < N_IN; i++) begin : g_xp
        assign gated[i] = hw_in[i*SAMPLE_W +: SAMPLE_W] & {SAMPLE_W{xp_en[i]}};
    end

    always_comb begin
        merged = '0;
        for (int i = 0; i < N_IN; i++) merged = merged | gated[i];
    end

    always_ff @(posedge clk) begin
        if (rst) col_out <= '0;
        else     col_out <= merged;
    end

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (xp_en == '0) |=> (col_out == '0)); // R6
endmodule

// File: rtl/pcm_space_switch.sv
module pcm_space_switch #(
    parameter int N_IN   = 5,
    parameter int N_OUT  = 3,
    parameter int N_SLOT = 8,
    localparam int SW     = pcm_sw_pkg::SAMPLE_W,
    localparam int SRC_W  = pcm_sw_pkg::idx_w(N_IN),
    localparam int COL_W  = pcm_sw_pkg::idx_w(N_OUT),
    localparam int SLOT_W = pcm_sw_pkg::idx_w(N_SLOT)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  frame_sync,
    input  logic [N_IN*SW-1:0]    hw_in,
    output logic [N_OUT*SW-1:0]   hw_out,
    input  logic                  wr_en,
    input  logic [COL_W-1:0]      wr_col,
    input  logic [SLOT_W-1:0]     wr_slot,
    input  logic [SRC_W-1:0]      wr_src,
    input  logic                  wr_valid
);
    logic [SLOT_W-1:0] cur_slot;

    pcm_slot_ctr #(.N_SLOT(N_SLOT)) u_slot (
        .clk        (clk),
        .rst        (rst),
        .frame_sync (frame_sync),
        .cur_slot   (cur_slot)
    );

    for (genvar j = 0; j < N_OUT; j++) begin : g_col
        logic [N_IN-1:0] xp_en;
        logic            col_wr;

        assign col_wr = wr_en && (wr_col == COL_W'(j));

        pcm_conn_mem #(.N_IN(N_IN), .N_SLOT(N_SLOT)) u_mem (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (col_wr),
            .wr_slot  (wr_slot),
            .wr_src   (wr_src),
            .wr_valid (wr_valid),
            .rd_slot  (cur_slot),
            .xp_en    (xp_en)
        );

        pcm_xpoint_col #(.N_IN(N_IN)) u_xp (
            .clk     (clk),
            .rst     (rst),
            .hw_in   (hw_in),
            .xp_en   (xp_en),
            .col_out (hw_out[j*SW +: SW])
        );
    end

    AST_RESET_OUT: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (hw_out == '0)); // R1
endmodule

// File: tb/tb_pcm_space_switch.sv
module tb_pcm_space_switch;
    localparam int K  = 5;
    localparam int M  = 3;
    localparam int N  = 8;
    localparam int SW = 8;

    logic              clk = 1'b0;
    logic              rst;
    logic              frame_sync;
    logic [K*SW-1:0]   hw_in;
    logic [M*SW-1:0]   hw_out;
    logic              wr_en;
    logic [1:0]        wr_col;
    logic [2:0]        wr_slot;
    logic [2:0]        wr_src;
    logic              wr_valid;

    pcm_space_switch #(.N_IN(K), .N_OUT(M), .N_SLOT(N)) dut (
        .clk(clk), .rst(rst), .frame_sync(frame_sync), .hw_in(hw_in),
        .hw_out(hw_out), .wr_en(wr_en), .wr_col(wr_col), .wr_slot(wr_slot),
        .wr_src(wr_src), .wr_valid(wr_valid)
    );

    always #5 clk = ~clk;

    int    total = 0;
    int    bad   = 0;
    bit    done  = 0;
    string tag   = "R1";

    // behavioural reference: connection table, frame position, expected outputs
    int ref_src [M][N];
    bit ref_vld [M][N];
    int ref_slot = 0;
    int exp_out [M];

    task automatic check_outputs();
        for (int j = 0; j < M; j++) begin
            total++;
            if (int'(hw_out[j*SW +: SW]) != exp_out[j]) begin
                bad++;
                $display("FAIL %s out%0d slot-step: actual=%0d expected=%0d",
                         tag, j, hw_out[j*SW +: SW], exp_out[j]);
            end
        end
    endtask

    // one cycle: drive at negedge, model the slot, compare after the next posedge
    task automatic step(input bit fs, input bit we, input int col,
                        input int slot, input int src, input bit vld);
        int cur;
        int samp [K];
        frame_sync = fs;
        wr_en      = we;
        wr_col     = col[1:0];
        wr_slot    = slot[2:0];
        wr_src     = src[2:0];
        wr_valid   = vld;
        for (int i = 0; i < K; i++) begin
            samp[i] = int'($urandom_range(255, 0));
            hw_in[i*SW +: SW] = samp[i][7:0];
        end
        cur = fs ? 0 : ref_slot;
        for (int j = 0; j < M; j++) begin
            if (ref_vld[j][cur] && ref_src[j][cur] < K) exp_out[j] = samp[ref_src[j][cur]];
            else exp_out[j] = 0;
        end
        if (we && col < M) begin
            ref_src[col][slot] = src;
            ref_vld[col][slot] = vld;
        end
        ref_slot = (cur + 1) % N;
        @(negedge clk);
        check_outputs();
    endtask

    task automatic idle(input int cycles);
        for (int c = 0; c < cycles; c++) step(0, 0, 0, 0, 0, 0);
    endtask

    task automatic put(input int col, input int slot, input int src, input bit vld);
        step(0, 1, col, slot, src, vld);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int j = 0; j < M; j++)
            for (int s = 0; s < N; s++) begin
                ref_src[j][s] = 0;
                ref_vld[j][s] = 0;
            end
        rst = 1; frame_sync = 0; wr_en = 0; wr_col = 0; wr_slot = 0;
        wr_src = 0; wr_valid = 0; hw_in = '1;
        for (int j = 0; j < M; j++) exp_out[j] = 0;
        repeat (3) @(negedge clk);
        tag = "R1";
        check_outputs();
        rst = 0;
        idle(10);                                   // R1: empty table keeps outputs 0

        tag = "R8";                                 // writes while the frame runs
        for (int s = 0; s < N; s++) put(0, s, s % K, 1);
        tag = "R3";
        idle(16);

        tag = "R4";
        for (int s = 0; s < N; s++) put(1, s, (s + 2) % K, 1);
        idle(16);

        tag = "R2";
        idle(3);
        step(1, 0, 0, 0, 0, 0);
        idle(11);
        step(1, 0, 0, 0, 0, 0);
        idle(3);
        step(1, 0, 0, 0, 0, 0);
        idle(10);

        tag = "R5";
        for (int j = 0; j < M; j++) put(j, 3, 4, 1);
        idle(16);

        tag = "R6";
        put(0, 2, 1, 0);
        idle(16);

        tag = "R7";
        put(1, 5, 6, 1);
        put(1, 6, 5, 1);
        put(2, 0, 7, 1);
        idle(16);

        tag = "R11";
        put(3, 0, 1, 1);
        put(3, 4, 2, 1);
        idle(16);

        tag = "R10";
        put(2, 4, 1, 1);
        idle(16);

        tag = "R8";
        put(0, ref_slot, 3, 1);                     // slot being read now
        put(1, ref_slot, 0, 1);
        put(2, (ref_slot + 1) % N, 2, 1);           // slot read in the next cycle
        idle(2);
        put(0, ref_slot, 4, 0);
        idle(16);

        tag = "R9";
        for (int s = 0; s < N; s++) put(2, s, (s * 3) % K, 1);
        idle(16);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule